// File: doc/BRIEF.md
# I2C DAC Register Command Controller

This block holds the register state of a single-channel 16-bit DAC that is written and read over I2C. It sits behind a byte-level I2C target front end. That front end handles SCL and SDA, matches the address, and passes on the following as single-cycle pulses: start and stop events, an address match with its read/write bit, each received byte, the end of each acknowledge cycle, and the master's ACK or NACK after each byte the block sends. The block drives the 16-bit DAC code and a 3-bit power-down mode. It also presents the byte that the front end shifts out on a read.

A write transfer carries three bytes: a command byte, then the upper data byte, then the lower data byte. Data can pass through two stages. The first is a holding register. The second is the live output register, and it feeds the converter. The two update bits of the command byte pick one of four actions: stage only, stage and load, load from the stage, or broadcast load. A power-down flag in the command byte makes the top three bits of the upper data byte a power-down mode in place of data. Nothing reaches the outputs until the acknowledge after the lower data byte has completed. A transfer cut short by a stop or a new start is dropped.

A read returns the upper data byte first, then the lower data byte, then the last accepted command byte. The byte pointer advances only on a master ACK.

Top module: `i2c_dac_cmd_ctrl`

## Requirements
- R1: After reset, dac_code is 0, pd_mode is 3'b000, and a read returns three zero bytes.
- R2: When command bits [5:4] are 2'b00, the 16-bit word {upper byte, lower byte} is written into the holding register only, and dac_code and pd_mode keep their values.
- R3: When command bits [5:4] are 2'b01, the word is written into the holding register and is also loaded. If command bit 0 is 0, dac_code takes the word and pd_mode becomes 3'b000.
- R4: When command bits [5:4] are 2'b10, the holding register contents are loaded and the received data bytes have no effect.
- R5: When command bits [5:4] are 2'b11 (broadcast), bit 2 = 0 loads from the holding register and bit 2 = 1 loads the received word. Bits 7:6 do not matter, and the holding register is unchanged.
- R6: When command bit 0 is 1, the word is a power-down command. Loading it sets pd_mode to word bits [15:13] and leaves dac_code unchanged. A power-down command staged with [5:4] = 2'b00 takes effect when it is loaded later.
- R7: A command byte with bit 3 set, bit 1 set, or bit 2 set outside broadcast is rejected. No register changes, and the stored command byte is not updated.
- R8: Outputs change only in the cycle after the ack_done pulse that follows the lower data byte. Receiving the lower data byte alone changes nothing.
- R9: A start, stop or new address event that arrives before that acknowledge ends discards the transfer, and no register changes.
- R10: On a read, tx_byte is the upper byte at first. Each master ACK advances it to the lower byte and then to the command byte, where it stays. A NACK freezes the pointer for the rest of the transfer.
- R11: When the stored command byte has bits [5:4] = 00 and bit 2 = 0, the data bytes read back come from the holding register. Otherwise they come from the word most recently loaded.
- R12: Every start event and every address match returns the read pointer to the upper data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | Start or repeated-start pulse |
| stop_evt | input | 1 | Stop pulse |
| addr_valid | input | 1 | Address matched pulse |
| addr_rw | input | 1 | Read/write bit of the matched address, 1 = read |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ack_done | input | 1 | End of the acknowledge cycle after a received byte |
| mack_valid | input | 1 | Master acknowledge slot after a sent byte |
| master_ack | input | 1 | 1 = master ACK, 0 = NACK |
| tx_byte | output | 8 | Byte to send on a read |
| dac_code | output | 16 | DAC output code |
| pd_mode | output | 3 | Power-down mode, 000 = normal operation |

## Verification
The main sweep sends all 256 command byte values in turn, each with a different data word. This covers every update mode with both power-down flag values, broadcast with either source and arbitrary upper bits, and all reserved-bit violations. After each transfer the outputs and a full read-back are compared with a bench model built from the requirements. Because the holding register already holds earlier data, the sweep tells a load from the stage apart from a load of the new word. Directed sequences then separate the commit instant from the arrival of the lower byte. They also show that a stop or start abort is silent, and that the read pointer returns home on a new start and holds after a NACK.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 2 * BYTE_W;
    localparam int PD_W    = 3;
    localparam int PD_LSB  = DATA_W - PD_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PD_W-1:0]   pd_t;

    // Update action selected by command bits [5:4]
    typedef enum logic [1:0] {
        UPD_STAGE = 2'b00,
        UPD_BOTH  = 2'b01,
        UPD_LOAD  = 2'b10,
        UPD_BCAST = 2'b11
    } upd_mode_e;

    // Command byte, MSB first
    typedef struct packed {
        logic [1:0] grp;      // [7:6] broadcast group, unused here
        upd_mode_e  mode;     // [5:4]
        logic       rsv3;     // [3] must be zero
        logic       src_new;  // [2] broadcast source select
        logic       rsv1;     // [1] must be zero
        logic       pd_flag;  // [0] power-down command
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        word_t word;
    } cmd_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_CTRL,
        W_MSB,
        W_LSB,
        W_ARMED,
        W_DONE
    } wr_state_e;

    typedef enum logic [1:0] {
        RB_MS   = 2'd0,
        RB_LS   = 2'd1,
        RB_CTRL = 2'd2
    } rb_ptr_e;

    function automatic logic ctrl_legal(ctrl_t c);
        return !c.rsv3 && !c.rsv1 && (!c.src_new || c.mode == UPD_BCAST);
    endfunction

    function automatic pd_t pd_field(word_t w);
        return w[DATA_W-1:PD_LSB];
    endfunction

    function automatic logic shows_stage(ctrl_t c);
        return (c.mode == UPD_STAGE) && !c.src_new;
    endfunction

endpackage

// File: rtl/dacctl_wr_decode.sv
module dacctl_wr_decode
    import dacctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_evt,
    input  logic  stop_evt,
    input  logic  addr_valid,
    input  logic  addr_rw,
    input  logic  rx_valid,
    input  byte_t rx_byte,
    input  logic  ack_done,
    output cmd_t  cmd,
    output logic  commit
);

    wr_state_e st;
    logic      abort;

    assign abort = start_evt || stop_evt || addr_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= W_IDLE;
            cmd <= '0;
        end else if (start_evt || stop_evt) begin
            st <= W_IDLE;
        end else if (addr_valid) begin
            st <= addr_rw ? W_IDLE : W_CTRL;
        end else begin
            unique case (st)
                W_CTRL: if (rx_valid) begin
                    cmd.ctrl <= ctrl_t'(rx_byte);
                    st       <= W_MSB;
                end
                W_MSB: if (rx_valid) begin
                    cmd.word[DATA_W-1:BYTE_W] <= rx_byte;
                    st                        <= W_LSB;
                end
                W_LSB: if (rx_valid) begin
                    cmd.word[BYTE_W-1:0] <= rx_byte;
                    st                   <= W_ARMED;
                end
                W_ARMED: if (ack_done) st <= W_DONE;
                default: ;
            endcase
        end
    end

    assign commit = (st == W_ARMED) && ack_done && !abort && ctrl_legal(cmd.ctrl);

    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (start_evt || stop_evt) |=> !commit); // R9

    AST_COMMIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        commit |-> !cmd.ctrl.rsv3 && !cmd.ctrl.rsv1); // R7

endmodule

// File: rtl/dacctl_regs.sv
module dacctl_regs
    import dacctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  commit,
    input  cmd_t  cmd,
    output word_t dac_code,
    output pd_t   pd_mode,
    output word_t stage_word,
    output word_t load_word,
    output ctrl_t ctrl_q
);

    logic  stage_pd;
    logic  wr_stage;
    logic  do_load;
    logic  take_new;
    word_t apply_word;
    logic  apply_pd;

    always_comb begin
        wr_stage = 1'b0;
        do_load  = 1'b0;
        take_new = 1'b0;
        unique case (cmd.ctrl.mode)
            UPD_STAGE: wr_stage = 1'b1;
            UPD_BOTH: begin
                wr_stage = 1'b1;
                do_load  = 1'b1;
                take_new = 1'b1;
            end
            UPD_LOAD:  do_load = 1'b1;
            UPD_BCAST: begin
                do_load  = 1'b1;
                take_new = cmd.ctrl.src_new;
            end
            default: ;
        endcase
        apply_word = take_new ? cmd.word : stage_word;
        apply_pd   = take_new ? cmd.ctrl.pd_flag : stage_pd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code   <= '0;
            pd_mode    <= '0;
            stage_word <= '0;
            stage_pd   <= 1'b0;
            load_word  <= '0;
            ctrl_q     <= '0;
        end else if (commit) begin
            ctrl_q <= cmd.ctrl;
            if (wr_stage) begin
                stage_word <= cmd.word;
                stage_pd   <= cmd.ctrl.pd_flag;
            end
            if (do_load) begin
                load_word <= apply_word;
                if (apply_pd) begin
                    pd_mode <= pd_field(apply_word);
                end else begin
                    dac_code <= apply_word;
                    pd_mode  <= '0;
                end
            end
        end
    end

    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(dac_code) && $stable(pd_mode)); // R8

    AST_LOAD_WAKES: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.ctrl.mode == UPD_BOTH && !cmd.ctrl.pd_flag) |=> pd_mode == '0); // R3

    AST_LOAD_KEEPS_STAGE: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.ctrl.mode == UPD_LOAD) |=> $stable(stage_word)); // R4

    AST_STAGE_KEEPS_DAC: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.ctrl.mode == UPD_STAGE) |=> $stable(dac_code) && $stable(pd_mode)); // R2

endmodule

// File: rtl/dacctl_rdback.sv
module dacctl_rdback
    import dacctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_evt,
    input  logic  stop_evt,
    input  logic  addr_valid,
    input  logic  addr_rw,
    input  logic  mack_valid,
    input  logic  master_ack,
    input  ctrl_t ctrl_q,
    input  word_t stage_word,
    input  word_t load_word,
    output byte_t tx_byte
);

    rb_ptr_e ptr;
    logic    active;
    word_t   rb_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= RB_MS;
            active <= 1'b0;
        end else if (start_evt || stop_evt) begin
            ptr    <= RB_MS;
            active <= 1'b0;
        end else if (addr_valid) begin
            ptr    <= RB_MS;
            active <= addr_rw;
        end else if (mack_valid && active) begin
            if (master_ack) begin
                unique case (ptr)
                    RB_MS:   ptr <= RB_LS;
                    default: ptr <= RB_CTRL;
                endcase
            end else begin
                active <= 1'b0;
            end
        end
    end

    assign rb_word = shows_stage(ctrl_q) ? stage_word : load_word;

    always_comb begin
        unique case (ptr)
            RB_MS:   tx_byte = rb_word[DATA_W-1:BYTE_W];
            RB_LS:   tx_byte = rb_word[BYTE_W-1:0];
            default: tx_byte = byte_t'(ctrl_q);
        endcase
    end

    AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ptr != rb_ptr_e'(2'd3)); // R10

    AST_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
        (start_evt || addr_valid) |=> ptr == RB_MS); // R12

    AST_NACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mack_valid && !master_ack && !start_evt && !stop_evt && !addr_valid)
            |=> $stable(ptr)); // R10

endmodule

// File: rtl/i2c_dac_cmd_ctrl.sv
module i2c_dac_cmd_ctrl
    import dacctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_evt,
    input  logic        stop_evt,
    input  logic        addr_valid,
    input  logic        addr_rw,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        ack_done,
    input  logic        mack_valid,
    input  logic        master_ack,
    output logic [7:0]  tx_byte,
    output logic [15:0] dac_code,
    output logic [2:0]  pd_mode
);

    cmd_t  cmd;
    logic  commit;
    word_t stage_word;
    word_t load_word;
    ctrl_t ctrl_q;

    dacctl_wr_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .addr_valid (addr_valid),
        .addr_rw    (addr_rw),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .ack_done   (ack_done),
        .cmd        (cmd),
        .commit     (commit)
    );

    dacctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .cmd        (cmd),
        .dac_code   (dac_code),
        .pd_mode    (pd_mode),
        .stage_word (stage_word),
        .load_word  (load_word),
        .ctrl_q     (ctrl_q)
    );

    dacctl_rdback u_rb (
        .clk        (clk),
        .rst        (rst),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .addr_valid (addr_valid),
        .addr_rw    (addr_rw),
        .mack_valid (mack_valid),
        .master_ack (master_ack),
        .ctrl_q     (ctrl_q),
        .stage_word (stage_word),
        .load_word  (load_word),
        .tx_byte    (tx_byte)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> dac_code == '0 && pd_mode == '0); // R1

endmodule

// File: tb/sim_i2c_dac_cmd_ctrl.sv
module sim_i2c_dac_cmd_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_evt = 1'b0, stop_evt = 1'b0;
    logic        addr_valid = 1'b0, addr_rw = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ack_done = 1'b0;
    logic        mack_valid = 1'b0, master_ack = 1'b0;
    logic [7:0]  tx_byte;
    logic [15:0] dac_code;
    logic [2:0]  pd_mode;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model
    logic [15:0] m_stage = '0, m_load = '0, m_dac = '0;
    logic        m_spd = 1'b0;
    logic [2:0]  m_pd = '0;
    logic [7:0]  m_ctrl = '0;

    always #5 clk = ~clk;

    i2c_dac_cmd_ctrl u0 (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .addr_valid(addr_valid), .addr_rw(addr_rw), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .ack_done(ack_done), .mack_valid(mack_valid),
        .master_ack(master_ack), .tx_byte(tx_byte), .dac_code(dac_code),
        .pd_mode(pd_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
    endtask
    task automatic ev_stop();
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
    endtask
    task automatic ev_addr(input logic rw);
        @(negedge clk) begin addr_valid = 1'b1; addr_rw = rw; end
        @(negedge clk) addr_valid = 1'b0;
    endtask
    task automatic ev_byte(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask
    task automatic ev_ack();
        @(negedge clk) ack_done = 1'b1;
        @(negedge clk) ack_done = 1'b0;
    endtask
    task automatic ev_mack(input logic a);
        @(negedge clk) begin mack_valid = 1'b1; master_ack = a; end
        @(negedge clk) mack_valid = 1'b0;
    endtask

    task automatic write3(input logic [7:0] c, input logic [15:0] w);
        ev_start();
        ev_addr(1'b0);
        ev_byte(c);      ev_ack();
        ev_byte(w[15:8]); ev_ack();
        ev_byte(w[7:0]); ev_ack();
        ev_stop();
    endtask

    task automatic m_apply(input logic [15:0] w, input logic pdf);
        m_load = w;
        if (pdf) m_pd = w[15:13];
        else begin m_dac = w; m_pd = 3'b000; end
    endtask

    task automatic model(input logic [7:0] c, input logic [15:0] w);
        if (c[3] || c[1] || (c[2] && c[5:4] != 2'b11)) return; // R7
        m_ctrl = c;
        case (c[5:4])
            2'b00: begin m_stage = w; m_spd = c[0]; end
            2'b01: begin m_stage = w; m_spd = c[0]; m_apply(w, c[0]); end
            2'b10: m_apply(m_stage, m_spd);
            default: if (c[2]) m_apply(w, c[0]); else m_apply(m_stage, m_spd);
        endcase
    endtask

    task automatic readback(input string tag);
        logic [15:0] rw;
        rw = (m_ctrl[5:4] == 2'b00 && !m_ctrl[2]) ? m_stage : m_load; // R11
        ev_start();
        ev_addr(1'b1);
        chk({tag, " rb MS"}, 32'(tx_byte), 32'(rw[15:8]));
        ev_mack(1'b1);
        chk({tag, " rb LS"}, 32'(tx_byte), 32'(rw[7:0]));
        ev_mack(1'b1);
        chk({tag, " rb ctrl"}, 32'(tx_byte), 32'(m_ctrl));
        ev_mack(1'b1);
        chk("R10 saturate", 32'(tx_byte), 32'(m_ctrl));
        ev_mack(1'b0);
        ev_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dac", 32'(dac_code), 0);
        chk("R1 pd", 32'(pd_mode), 0);
        readback("R1");

        // R8: lower byte alone does not commit
        ev_start(); ev_addr(1'b0);
        ev_byte(8'h10); ev_ack();
        ev_byte(8'hAB); ev_ack();
        ev_byte(8'hCD);
        chk("R8 before ack", 32'(dac_code), 0);
        ev_ack();
        chk("R8 after ack", 32'(dac_code), 32'hABCD);
        ev_stop();
        model(8'h10, 16'hABCD);

        // R9: stop before final ack
        ev_start(); ev_addr(1'b0);
        ev_byte(8'h10); ev_ack();
        ev_byte(8'h12); ev_ack();
        ev_byte(8'h34);
        ev_stop();
        ev_ack();
        chk("R9 stop abort", 32'(dac_code), 32'hABCD);
        // R9: repeated start before final ack
        ev_start(); ev_addr(1'b0);
        ev_byte(8'h10); ev_ack();
        ev_byte(8'h56);
        ev_start();
        ev_ack();
        chk("R9 start abort", 32'(dac_code), 32'hABCD);
        readback("R9");

        // R12: new start during a read returns to MS
        ev_start(); ev_addr(1'b1);
        ev_mack(1'b1);
        chk("R12 at LS", 32'(tx_byte), 32'hCD);
        ev_start(); ev_addr(1'b1);
        chk("R12 home", 32'(tx_byte), 32'hAB);
        ev_mack(1'b0);
        ev_mack(1'b1);
        chk("R10 nack holds", 32'(tx_byte), 32'hAB);
        ev_stop();

        // Sweep every command byte
        for (int i = 0; i < 256; i++) begin
            logic [7:0] c;
            c = 8'(i);
            w = 16'(i * 16'h9E37 + 16'h1357);
            if (c[3] || c[1] || (c[2] && c[5:4] != 2'b11)) tag = "R7";
            else if (c[0] && c[5:4] != 2'b10) tag = "R6";
            else case (c[5:4])
                2'b00: tag = "R2";
                2'b01: tag = "R3";
                2'b10: tag = "R4";
                default: tag = "R5";
            endcase
            write3(c, w);
            model(c, w);
            chk({tag, " dac"}, 32'(dac_code), 32'(m_dac));
            chk({tag, " pd"}, 32'(pd_mode), 32'(m_pd));
            readback("R11");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule